// File: doc/BRIEF.md
# Two-Wire Programming Command Master

This block sits on the host side of a two-wire in-circuit programming link. It generates the serial clock and drives or samples the bidirectional data line, so that a target device receives instructions and returns register contents. A valid/ready request selects one of two commands. An execute command shifts a 24-bit instruction into the target. A read-out command collects a 16-bit value from the target. A separate request flag selects the lengthened execute that the target expects as its first command after reset.

Each serial clock has a low phase followed by a high phase, and each phase lasts a programmable number of system cycles. The master changes the data line only while the clock is low. The target samples on the rising edge, and the master samples returned bits on the rising edge too. All fields go out least significant bit first. For a read-out, the master releases the data line after the command code and waits out a fixed idle gap. It then captures sixteen bits and takes the line back. It presents the result with a one-cycle completion strobe. An execute needs four further serial clocks to run in the target. The master provides none of its own: the four code clocks of the next command supply them.

Top module: `pgm_cmd_master`

## Requirements
- R1: Out of reset, and whenever idle, pgc_o is low, pgd_o is 0, pgd_oe_o is 1, req_ready_o is 1 and done_o is 0.
- R2: Every low phase and every high phase of pgc_o lasts div+1 system cycles, where div is the value of div_i captured when the request was accepted. Later changes of div_i have no effect on a command in progress.
- R3: pgd_o and pgd_oe_o change only at a falling edge of pgc_o or at acceptance, and stay constant while pgc_o is high.
- R4: An execute request (req_read_i=0, req_first_i=0) produces exactly 28 pgc_o clocks. The first four carry code 0000. The next 24 carry req_instr_i, bit 0 first.
- R5: A request with req_first_i=1 is an execute whatever the value of req_read_i. It produces 33 clocks: nine zero code bits, then req_instr_i bit 0 first.
- R6: A read-out request (req_read_i=1, req_first_i=0) produces exactly 28 clocks. The first four carry the code 4'b0001 bit 0 first, so the first clock carries a 1. Eight idle clocks and sixteen data clocks follow.
- R7: During a read-out, pgd_oe_o drops at the falling edge that ends code clock 4 and stays low through the last data clock. It returns to 1 at the falling edge that ends the command, in the same cycle that done_o rises. For every other command, pgd_oe_o stays 1.
- R8: rdata_o is built from pgd_i sampled at the rising edges of the sixteen data clocks. The first sampled bit becomes bit 0.
- R9: done_o is a single-cycle pulse in the cycle after the final falling edge of every command. req_ready_o is already 1 in that cycle.
- R10: A request is accepted when req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the next cycle until done_o. Request inputs presented while busy are ignored.
- R11: rdata_o keeps its value until the next read-out completes. Execute commands leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Master idle, request can be accepted |
| req_read_i | input | 1 | 1 selects read-out, 0 selects execute |
| req_first_i | input | 1 | Lengthened first execute after target reset |
| req_instr_i | input | 24 | Instruction word for an execute |
| div_i | input | DIV_W | Serial clock half-period minus one, in system cycles |
| pgc_o | output | 1 | Serial clock to target |
| pgd_o | output | 1 | Data line output value |
| pgd_oe_o | output | 1 | Data line output enable (0 = released) |
| pgd_i | input | 1 | Data line input value |
| rdata_o | output | 16 | Last read-out result |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The assertions check the line-level rules on every cycle. The data line and its enable stay still while the clock is high. The line is released only while a command is in progress, and only at a low phase. It is reclaimed exactly when done pulses. The idle lines are at rest, and the handshake drops ready after an accept. A bench target model that records each rising edge checks the rest. That covers the bit order and count of each command type, the 9-clock first code, the read gap and capture order, phase widths measured in time, and that stray requests and divider changes while busy are ignored.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int INSTR_W      = 24;
  localparam int RDATA_W      = 16;
  localparam int CODE_W       = 4;
  localparam int FIRST_CODE_W = 9;
  localparam int GAP_CLKS     = 8;

  localparam logic [CODE_W-1:0] CODE_EXEC = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_READ = 4'b0001;

  localparam int TX_W       = FIRST_CODE_W + INSTR_W;
  localparam int EXEC_CLKS  = CODE_W + INSTR_W;
  localparam int FIRST_CLKS = FIRST_CODE_W + INSTR_W;
  localparam int READ_CLKS  = CODE_W + GAP_CLKS + RDATA_W;
  localparam int CNT_W      = $clog2(FIRST_CLKS + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } pgm_state_e;
endpackage

// File: rtl/pgm_clk_div.sv
module pgm_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             half_end_o
);
  logic [DIV_W-1:0] cnt_q;

  assign half_end_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i || half_end_o)  cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pgm_tx_shift.sv
module pgm_tx_shift #(
  parameter int W = 33
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] sr_q;

  assign bit_o = sr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {1'b0, sr_q[W-1:1]};
  end
endmodule

// File: rtl/pgm_rx_shift.sv
module pgm_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  // LSb arrives first, so new bits enter at the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (shift_i) data_o <= {bit_i, data_o[W-1:1]};
  end
endmodule

// File: rtl/pgm_cmd_master.sv
module pgm_cmd_master
  import pgm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_read_i,
  input  logic               req_first_i,
  input  logic [INSTR_W-1:0] req_instr_i,
  input  logic [DIV_W-1:0]   div_i,
  output logic               pgc_o,
  output logic               pgd_o,
  output logic               pgd_oe_o,
  input  logic               pgd_i,
  output logic [RDATA_W-1:0] rdata_o,
  output logic               done_o
);
  pgm_state_e         state_q;
  logic [DIV_W-1:0]   div_q;
  logic               is_read_q;
  logic [CNT_W-1:0]   clk_idx_q, last_idx_q;
  logic               oe_q, done_q;
  logic [RDATA_W-1:0] rdata_q, rx_data;

  logic               accept, half_end, rise_ev, fall_ev, last_clk, capture;
  logic [TX_W-1:0]    tx_load;
  logic [CNT_W-1:0]   last_load;
  logic               read_load;

  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign rise_ev  = (state_q == ST_LOW)  && half_end;
  assign fall_ev  = (state_q == ST_HIGH) && half_end;
  assign last_clk = (clk_idx_q == last_idx_q);
  assign capture  = rise_ev && is_read_q && (clk_idx_q >= CNT_W'(CODE_W + GAP_CLKS));

  // command image, LSb goes out first; first-command flag overrides read
  always_comb begin
    if (req_first_i) begin
      tx_load   = {req_instr_i, {FIRST_CODE_W{1'b0}}};
      last_load = CNT_W'(FIRST_CLKS - 1);
      read_load = 1'b0;
    end else if (req_read_i) begin
      tx_load   = TX_W'(CODE_READ);
      last_load = CNT_W'(READ_CLKS - 1);
      read_load = 1'b1;
    end else begin
      tx_load   = TX_W'({req_instr_i, CODE_EXEC});
      last_load = CNT_W'(EXEC_CLKS - 1);
      read_load = 1'b0;
    end
  end

  pgm_clk_div #(.DIV_W(DIV_W)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (state_q != ST_IDLE),
    .div_i      (div_q),
    .half_end_o (half_end)
  );

  pgm_tx_shift #(.W(TX_W)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .data_i  (tx_load),
    .shift_i (fall_ev),
    .bit_o   (pgd_o)
  );

  pgm_rx_shift #(.W(RDATA_W)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (capture),
    .bit_i   (pgd_i),
    .data_o  (rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      div_q      <= '0;
      is_read_q  <= 1'b0;
      clk_idx_q  <= '0;
      last_idx_q <= '0;
      oe_q       <= 1'b1;
      done_q     <= 1'b0;
      rdata_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q    <= ST_LOW;
          div_q      <= div_i;
          is_read_q  <= read_load;
          last_idx_q <= last_load;
          clk_idx_q  <= '0;
          oe_q       <= 1'b1;
        end
        ST_LOW: if (rise_ev) state_q <= ST_HIGH;
        ST_HIGH: if (fall_ev) begin
          if (last_clk) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            oe_q    <= 1'b1;
            if (is_read_q) rdata_q <= rx_data;
          end else begin
            state_q   <= ST_LOW;
            clk_idx_q <= clk_idx_q + 1'b1;
            // release line once the read code has gone out
            if (is_read_q && clk_idx_q == CNT_W'(CODE_W - 1)) oe_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign pgc_o       = (state_q == ST_HIGH);
  assign pgd_oe_o    = oe_q;
  assign rdata_o     = rdata_q;
  assign done_o      = done_q;
endmodule

// File: rtl/pgm_cmd_master_chk.sv
module pgm_cmd_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic pgc_o,
  input logic pgd_o,
  input logic pgd_oe_o,
  input logic done_o
);
  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!pgc_o && pgd_oe_o && !pgd_o));

  assert_steady_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgc_o |-> ($stable(pgd_o) && $stable(pgd_oe_o)));

  assert_release_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgd_oe_o |-> !req_ready_o);

  assert_release_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pgd_oe_o) |-> !pgc_o);

  assert_reclaim_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgd_oe_o) |-> done_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  assert_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

bind pgm_cmd_master pgm_cmd_master_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .pgc_o       (pgc_o),
  .pgd_o       (pgd_o),
  .pgd_oe_o    (pgd_oe_o),
  .done_o      (done_o)
);

// File: tb/test_pgm_cmd_master.sv
`timescale 1ns/1ps
module test_pgm_cmd_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_read = 1'b0, req_first = 1'b0;
  logic [23:0] req_instr = '0;
  logic [7:0]  req_div = '0;
  logic        pgd_i = 1'b0;
  logic        req_ready_o, pgc_o, pgd_o, pgd_oe_o, done_o;
  logic [15:0] rdata_o;

  int checks = 0, failures = 0;
  int cycles = 0;

  pgm_cmd_master #(.DIV_W(8)) i_pgm_cmd_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_read_i(req_read), .req_first_i(req_first), .req_instr_i(req_instr),
    .div_i(req_div), .pgc_o(pgc_o), .pgd_o(pgd_o), .pgd_oe_o(pgd_oe_o),
    .pgd_i(pgd_i), .rdata_o(rdata_o), .done_o(done_o)
  );

  always #2.5 clk = ~clk;

  // target model / monitor
  logic [39:0] mon_bits, mon_oe;
  int          rises = 0;
  bit          tb_read = 1'b0;
  logic [15:0] read_val = '0;
  realtime     t_start = 0, t_rise = 0, t_fall = 0, exp_hw = 5.0;
  bit          width_bad = 1'b0, r3_bad = 1'b0;

  always @(posedge pgc_o) begin
    realtime lw;
    lw = $realtime - ((rises == 0) ? t_start : t_fall);
    if (lw > exp_hw + 0.1 || lw < exp_hw - 0.1) width_bad = 1'b1;
    if (rises < 40) begin
      mon_bits[rises] = pgd_o;
      mon_oe[rises]   = pgd_oe_o;
    end
    t_rise = $realtime;
    rises++;
  end

  always @(negedge pgc_o) begin
    realtime hw;
    t_fall = $realtime;
    hw = t_fall - t_rise;
    if (hw > exp_hw + 0.1 || hw < exp_hw - 0.1) width_bad = 1'b1;
    if (tb_read && rises >= 12 && rises < 28) pgd_i = read_val[rises-12];
    else pgd_i = 1'b0;
  end

  always @(negedge clk) begin
    if (pgc_o && rises > 0 && rises <= 40)
      if (pgd_o !== mon_bits[rises-1] || pgd_oe_o !== mon_oe[rises-1]) r3_bad = 1'b1;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // issue one command and wait for done; optionally disturb inputs while busy
  task automatic run_cmd(input bit rd, input bit first, input logic [23:0] instr,
                         input logic [7:0] div, input logic [15:0] rval,
                         input bit disturb, output int ready_busy);
    int n;
    tb_read = rd && !first;
    read_val = rval;
    exp_hw = (div + 1) * 5.0;
    rises = 0; width_bad = 1'b0; r3_bad = 1'b0; pgd_i = 1'b0;
    mon_bits = '0; mon_oe = '0;
    ready_busy = 0;
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_first = first; req_instr = instr; req_div = div;
    while (!req_ready_o) @(negedge clk);
    @(posedge clk);
    t_start = $realtime;
    @(negedge clk);
    if (disturb) begin
      req_read = 1'b1; req_first = 1'b1; req_instr = ~instr; req_div = 8'd0;
    end else begin
      req_valid = 1'b0;
    end
    n = 0;
    while (!done_o && n < 20000) begin
      if (req_ready_o) ready_busy++;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
  endtask

  task automatic test_reset();
    chk(pgc_o == 1'b0,      "R1 pgc idle", pgc_o, 0);
    chk(pgd_o == 1'b0,      "R1 pgd idle", pgd_o, 0);
    chk(pgd_oe_o == 1'b1,   "R1 oe idle", pgd_oe_o, 1);
    chk(req_ready_o == 1'b1,"R1 ready idle", req_ready_o, 1);
    chk(done_o == 1'b0,     "R1 done idle", done_o, 0);
  endtask

  task automatic test_exec(input logic [23:0] instr, input logic [7:0] div, input logic [15:0] keep);
    int rb;
    run_cmd(1'b0, 1'b0, instr, div, 16'h0, 1'b0, rb);
    chk(rises == 28,                 "R4 exec clock count", rises, 28);
    chk(mon_bits[3:0] == 4'b0000,    "R4 exec code", mon_bits[3:0], 0);
    chk(mon_bits[27:4] == instr,     "R4 exec instr bits", mon_bits[27:4], instr);
    chk(mon_oe[27:0] == 28'hFFFFFFF, "R7 exec oe held", mon_oe[27:0], 28'hFFFFFFF);
    chk(!width_bad,                  "R2 exec phase width", width_bad, 0);
    chk(!r3_bad,                     "R3 exec data steady high", r3_bad, 0);
    chk(done_o && req_ready_o,       "R9 exec done with ready", {done_o, req_ready_o}, 2'b11);
    chk(rdata_o == keep,             "R11 exec keeps rdata", rdata_o, keep);
    @(negedge clk);
    chk(!done_o,                     "R9 done single cycle", done_o, 0);
    chk(pgd_oe_o && !pgc_o && !pgd_o,"R1 idle after exec", {pgd_oe_o, pgc_o, pgd_o}, 3'b100);
  endtask

  task automatic test_read(input logic [15:0] rval, input logic [7:0] div);
    int rb;
    run_cmd(1'b1, 1'b0, 24'h0, div, rval, 1'b0, rb);
    chk(rises == 28,              "R6 read clock count", rises, 28);
    chk(mon_bits[3:0] == 4'b0001, "R6 read code", mon_bits[3:0], 4'b0001);
    chk(mon_oe[3:0] == 4'hF,      "R7 oe during code", mon_oe[3:0], 4'hF);
    chk(mon_oe[27:4] == 24'h0,    "R7 released gap and data", mon_oe[27:4], 0);
    chk(pgd_oe_o == 1'b1,         "R7 reclaimed at done", pgd_oe_o, 1);
    chk(rdata_o == rval,          "R8 read value", rdata_o, rval);
    chk(!width_bad,               "R2 read phase width", width_bad, 0);
    chk(!r3_bad,                  "R3 read data steady high", r3_bad, 0);
    chk(done_o,                   "R9 read done", done_o, 1);
    @(negedge clk);
    chk(!done_o && rdata_o == rval, "R11 rdata held", rdata_o, rval);
  endtask

  task automatic test_first(input logic [23:0] instr, input logic [15:0] keep);
    int rb;
    run_cmd(1'b1, 1'b1, instr, 8'd1, 16'hFFFF, 1'b0, rb);
    chk(rises == 33,                  "R5 first clock count", rises, 33);
    chk(mon_bits[8:0] == 9'h0,        "R5 first long code", mon_bits[8:0], 0);
    chk(mon_bits[32:9] == instr,      "R5 first instr bits", mon_bits[32:9], instr);
    chk(mon_oe[32:0] == 33'h1FFFFFFFF,"R5 first keeps line", mon_oe[31:0], 32'hFFFFFFFF);
    chk(rdata_o == keep,              "R5 first is not a read", rdata_o, keep);
  endtask

  task automatic test_busy(input logic [23:0] instr);
    int rb;
    run_cmd(1'b0, 1'b0, instr, 8'd2, 16'h0, 1'b1, rb);
    chk(rb == 0,                  "R10 ready low while busy", rb, 0);
    chk(rises == 28,              "R10 busy inputs ignored count", rises, 28);
    chk(mon_bits[27:4] == instr,  "R10 busy inputs ignored data", mon_bits[27:4], instr);
    chk(!width_bad,               "R2 div latched at accept", width_bad, 0);
    @(negedge clk);
    chk(req_ready_o,              "R10 ready after done", req_ready_o, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_first(24'h5A3C91, 16'h0000);
    test_exec(24'hA5C396, 8'd1, 16'h0000);
    test_read(16'hBEEF, 8'd0);
    test_read(16'h1234, 8'd2);
    test_exec(24'h0F00F1, 8'd0, 16'h1234);
    test_busy(24'hC0FFEE);
    test_read(16'h8001, 8'd3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule